// File: doc/BRIEF.md
# Binary to Residue Translator for Moduli One Away from a Power of Two

This block reduces an unsigned binary word to its residue modulo M, where M is either 2^m − 1 or 2^m + 1. The intended use is an interleaved memory with a prime number of banks. In that setting the bank index of every address is the address modulo the bank count, and the reduction has to finish within one access cycle. No divider, multiplier or lookup table is used. The input is cut into segments of p·m bits, with the lowest segment at the least significant end and a short top segment padded with zeros. Each segment is folded into the residue range by a short chain of conditional subtractions. The folded segments are then merged by a balanced tree of modulo-M adders.

For M = 2^m − 1 every segment carries weight +1. For M = 2^m + 1 a segment's weight is (2^(p·m))^j, which reduces to (−1)^(p·j) for segment index j. So with odd p, the odd-indexed segments are negated before they enter the tree. With even p, every segment is simply added. The parameters are the input width, m, the choice of −1 or +1, the segment multiple p, and whether the result is registered.

Data crosses the block's edge on valid/ready handshakes. An input word is taken on a clock edge where in_valid and in_ready are both high. A result is taken on an edge where out_valid and out_ready are both high. With the output register in place, in_ready is high whenever the output stage is empty or is being drained in the same cycle. While out_valid is high and out_ready is low, the result does not change. Without the output register, the block is purely combinational and the handshake passes straight through.

Top module: `modx_translator`

## Requirements
- R1: For M = 2^m − 1, out_res equals in_data mod M for every input value, with the input split into m-bit digits (p = 1, the 8-bit mod-7 case included).
- R2: For M = 2^m + 1 with p even, out_res equals in_data mod M, with all segments added and no sign changes.
- R3: For M = 2^m + 1 with p odd, out_res equals in_data mod M, with odd-indexed segments (index 0 at the least significant end) subtracted.
- R4: out_res always lies in [0, M−1]. Its width is m bits for 2^m − 1 and m+1 bits for 2^m + 1.
- R5: Boundary inputs reduce correctly: zero gives 0, any multiple of M gives 0, and the all-ones word gives (2^n − 1) mod M.
- R6: When n is not a multiple of p·m, the top segment is zero-extended. Values that set only the top bits reduce correctly (2^22 mod 17 = 13 at n = 23).
- R7: With the output register, a word is accepted when in_valid and in_ready are both high. Its result appears with out_valid high after the next rising clock edge. in_ready equals (not out_valid) or out_ready.
- R8: With the output register, while out_valid is high and out_ready is low, out_valid stays high and out_res holds its value. A word presented during that stall is not accepted.
- R9: While rst_n is low and after it is released, out_valid is low until a word is accepted.
- R10: Without the output register, out_valid follows in_valid, in_ready follows out_ready, and out_res is the residue of the current in_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block can take a word this cycle |
| in_data | input | N_BITS (23) | Unsigned binary value to reduce |
| out_valid | output | 1 | out_res holds a result |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_res | output | RW (5) | Residue, m+1 bits for 2^m+1 and m bits for 2^m−1 |

## Verification
The bench drives the all-ones word, exact multiples of M, words with only the padded top segment set, and the value M−1 itself. A fold chain that is one stage short would return M or more on these inputs. A wrong zero-extension would return a wrong value for the top-segment word. The same values go to a mod-17 instance with odd p, so a swapped segment sign shows up as a wrong residue there and not in the even-p instance. A stall test holds out_ready low while a second word waits. A slice that overwrites its output, or that takes the second word early, would show a changed out_res or a missing result.

// File: rtl/modx_pkg.sv
package modx_pkg;

  // Modulus for 2^m - 1 (plus = 0) or 2^m + 1 (plus = 1)
  function automatic int modx_modulus(input int m, input bit plus);
    return plus ? ((1 << m) + 1) : ((1 << m) - 1);
  endfunction

  // Bits needed to hold a residue in [0, M-1]
  function automatic int modx_res_w(input int m, input bit plus);
    return plus ? (m + 1) : m;
  endfunction

  // A segment of p*m bits at index j weighs (-1)^(p*j) under 2^m + 1
  function automatic bit modx_seg_neg(input bit plus, input int p, input int j);
    return plus && ((p % 2) == 1) && ((j % 2) == 1);
  endfunction

endpackage

// File: rtl/modx_add.sv
module modx_add #(
  parameter int M_BITS   = 4,
  parameter bit PLUS_ONE = 1'b1,
  localparam int MOD = modx_pkg::modx_modulus(M_BITS, PLUS_ONE),
  localparam int RW  = modx_pkg::modx_res_w(M_BITS, PLUS_ONE)
) (
  input  logic [RW-1:0] a,
  input  logic [RW-1:0] b,
  output logic [RW-1:0] s
);

  localparam int AW = RW + 1;

  logic [RW:0] t;
  assign t = {1'b0, a} + {1'b0, b};

  if (PLUS_ONE) begin : g_cmp_sub
    // Sum below 2M: one conditional subtraction lands it in range
    localparam logic [RW:0] MODW = AW'(MOD);
    assign s = (t >= MODW) ? RW'(t - MODW) : t[RW-1:0];
  end else begin : g_eac
    // End-around carry; an all-ones result is the second form of zero
    logic [RW-1:0] u;
    assign u = t[RW-1:0] + RW'(t[RW]);
    assign s = (&u) ? '0 : u;
  end

  always_comb begin
    if ((a < RW'(MOD)) && (b < RW'(MOD))) begin
      AST_ADD_MOD: assert (32'(s) == ((32'(a) + 32'(b)) % MOD));  // R1
    end
  end

endmodule

// File: rtl/modx_seg_fold.sv
module modx_seg_fold #(
  parameter int SEG_W    = 8,
  parameter int M_BITS   = 4,
  parameter bit PLUS_ONE = 1'b1,
  localparam int MOD = modx_pkg::modx_modulus(M_BITS, PLUS_ONE),
  localparam int RW  = modx_pkg::modx_res_w(M_BITS, PLUS_ONE)
) (
  input  logic [SEG_W-1:0] seg,
  output logic [RW-1:0]    res
);

  localparam int XW = (SEG_W > RW) ? SEG_W : RW;
  localparam int VW = XW + 1;
  localparam int K  = XW - RW + 1;   // stages: subtract M<<(K-1) down to M<<0

  for (genvar k = 0; k <= K; k++) begin : g_st
    logic [VW-1:0] v;
    if (k == 0) begin : g_in
      assign v = VW'(seg);
    end else begin : g_sub
      localparam logic [VW-1:0] SUB = VW'(MOD) << (K - k);
      assign v = (g_st[k-1].v >= SUB) ? (g_st[k-1].v - SUB) : g_st[k-1].v;
    end
  end

  assign res = g_st[K].v[RW-1:0];

  always_comb begin
    AST_FOLD_RANGE: assert (g_st[K].v < VW'(MOD));  // R4
  end

endmodule

// File: rtl/modx_core.sv
module modx_core #(
  parameter int N_BITS   = 23,
  parameter int M_BITS   = 4,
  parameter bit PLUS_ONE = 1'b1,
  parameter int SEG_MULT = 2,
  localparam int MOD = modx_pkg::modx_modulus(M_BITS, PLUS_ONE),
  localparam int RW  = modx_pkg::modx_res_w(M_BITS, PLUS_ONE)
) (
  input  logic [N_BITS-1:0] din,
  output logic [RW-1:0]     res
);

  localparam int SEG_W = SEG_MULT * M_BITS;
  localparam int SEGS  = (N_BITS + SEG_W - 1) / SEG_W;
  localparam int LVLS  = (SEGS > 1) ? $clog2(SEGS) : 0;
  localparam int LEAF0 = 1 << LVLS;
  localparam int PAD_W = SEGS * SEG_W;

  logic [PAD_W-1:0] din_pad;
  assign din_pad = PAD_W'(din);   // top segment zero-extended

  for (genvar d = 0; d <= LVLS; d++) begin : g_lvl
    localparam int NN = LEAF0 >> d;
    logic [RW-1:0] v [0:NN-1];
    if (d == 0) begin : g_leaf
      for (genvar j = 0; j < NN; j++) begin : g_seg
        if (j < SEGS) begin : g_used
          logic [RW-1:0] r;
          modx_seg_fold #(
            .SEG_W(SEG_W), .M_BITS(M_BITS), .PLUS_ONE(PLUS_ONE)
          ) u_fold (
            .seg(din_pad[j*SEG_W +: SEG_W]),
            .res(r)
          );
          if (modx_pkg::modx_seg_neg(PLUS_ONE, SEG_MULT, j)) begin : g_neg
            assign v[j] = (r == '0) ? '0 : (RW'(MOD) - r);
          end else begin : g_pos
            assign v[j] = r;
          end
        end else begin : g_pad
          assign v[j] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < NN; j++) begin : g_add
        modx_add #(.M_BITS(M_BITS), .PLUS_ONE(PLUS_ONE)) u_add (
          .a(g_lvl[d-1].v[2*j]),
          .b(g_lvl[d-1].v[2*j+1]),
          .s(v[j])
        );
      end
    end
  end

  assign res = g_lvl[LVLS].v[0];

endmodule

// File: rtl/modx_translator.sv
module modx_translator #(
  parameter int N_BITS   = 23,
  parameter int M_BITS   = 4,
  parameter bit PLUS_ONE = 1'b1,
  parameter int SEG_MULT = 2,
  parameter bit OUT_REG  = 1'b1,
  localparam int MOD = modx_pkg::modx_modulus(M_BITS, PLUS_ONE),
  localparam int RW  = modx_pkg::modx_res_w(M_BITS, PLUS_ONE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N_BITS-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RW-1:0]     out_res
);

  logic [RW-1:0] core_res;

  modx_core #(
    .N_BITS(N_BITS), .M_BITS(M_BITS), .PLUS_ONE(PLUS_ONE), .SEG_MULT(SEG_MULT)
  ) u_core (
    .din(in_data),
    .res(core_res)
  );

  if (OUT_REG) begin : g_slice
    logic          vld_q;
    logic [RW-1:0] res_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_res   = res_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) res_q <= core_res;
      end
    end

    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);  // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));  // R8
    AST_ACCEPT_RES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=>
        (out_valid && (out_res == RW'(64'($past(in_data)) % 64'(MOD)))));  // R2
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_res < RW'(MOD)));  // R4
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_res   = core_res;
  end

endmodule

// File: tb/modx_translator_tb_top.sv
`timescale 1ns/1ps
module modx_translator_tb_top;

  localparam int NTV = 13;
  localparam logic [22:0] TV_IN [NTV] = '{
    23'h000000, 23'h7FFFFF, 23'h000011, 23'h000010, 23'h7FFFF7,
    23'h123456, 23'h00FF00, 23'h0000FF, 23'h000100, 23'h400000,
    23'h55AA33, 23'h0ABCDE, 23'h7FFFFE };
  localparam logic [4:0] TV_EXP [NTV] = '{
    5'd0, 5'd8, 5'd0, 5'd16, 5'd0,
    5'd3, 5'd0, 5'd0, 5'd1, 5'd13,
    5'd0, 5'd12, 5'd7 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [22:0] in_data  = '0;
  logic        out_ready = 1'b1;
  logic        rdy_a, vld_a, rdy_b, vld_b;
  logic [4:0]  res_a, res_b;

  logic        in_valid7 = 1'b1;
  logic [7:0]  in_data7  = '0;
  logic        out_ready7 = 1'b1;
  logic        rdy7, vld7;
  logic [2:0]  res7;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  // mod 17, segments of 8 bits (even p)
  modx_translator #(.N_BITS(23), .M_BITS(4), .PLUS_ONE(1'b1), .SEG_MULT(2), .OUT_REG(1'b1))
  dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a), .in_data(in_data),
         .out_valid(vld_a), .out_ready(out_ready), .out_res(res_a));

  // mod 17, segments of 4 bits (odd p, alternating signs)
  modx_translator #(.N_BITS(23), .M_BITS(4), .PLUS_ONE(1'b1), .SEG_MULT(1), .OUT_REG(1'b1))
  dut_p1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b), .in_data(in_data),
          .out_valid(vld_b), .out_ready(out_ready), .out_res(res_b));

  // mod 7, 8-bit input, combinational
  modx_translator #(.N_BITS(8), .M_BITS(3), .PLUS_ONE(1'b0), .SEG_MULT(1), .OUT_REG(1'b0))
  dut_m7 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid7), .in_ready(rdy7), .in_data(in_data7),
          .out_valid(vld7), .out_ready(out_ready7), .out_res(res7));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One word through the registered instances; result sampled at the following negedge
  task automatic send(input logic [22:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    logic [31:0] x;
    x = 32'h1ACE5EED;

    // Reset state (R9)
    repeat (3) @(negedge clk);
    check("R9", "out_valid in reset (dut_i)", vld_a, 0);
    check("R9", "out_valid in reset (dut_p1)", vld_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "out_valid after reset", vld_a, 0);
    check("R7", "in_ready when empty", rdy_a, 1);

    // Table walk: mod 17, even and odd p (R2 R3 R5 R6)
    for (int i = 0; i < NTV; i++) begin
      send(TV_IN[i]);
      check("R7", "out_valid after accept", vld_a, 1);
      check("R2", $sformatf("even p res for %h", TV_IN[i]), res_a, TV_EXP[i]);
      check("R3", $sformatf("odd p res for %h", TV_IN[i]), res_b, TV_EXP[i]);
      if (TV_IN[i] == 23'h400000) check("R6", "top segment only", res_a, 13);
      if (TV_IN[i] == 23'h7FFFFF) check("R5", "all ones", res_b, 8);
    end

    // Random words compared with the % operator (R2 R3 R4)
    for (int i = 0; i < 150; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      send(x[22:0]);
      check("R2", "random even p", res_a, longint'(x[22:0]) % 17);
      check("R3", "random odd p", res_b, longint'(x[22:0]) % 17);
      check("R4", "range", (res_a < 17) ? 1 : 0, 1);
    end
    @(negedge clk);
    check("R7", "drained when idle", vld_a, 0);

    // Exhaustive mod 7 on the combinational instance (R1 R5 R10)
    for (int v = 0; v < 256; v++) begin
      in_data7 = 8'(v);
      #1;
      check("R1", $sformatf("mod 7 of %0d", v), res7, v % 7);
    end
    in_data7 = 8'd252;
    #1 check("R5", "multiple of 7", res7, 0);
    in_data7 = 8'hFF;
    #1 check("R5", "all ones mod 7", res7, 3);
    check("R10", "out_valid follows in_valid", vld7, 1);
    in_valid7 = 1'b0;
    out_ready7 = 1'b0;
    #1 check("R10", "out_valid low", vld7, 0);
    check("R10", "in_ready follows out_ready", rdy7, 0);

    // Back-pressure (R7 R8)
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = 23'h123456;
    @(negedge clk);
    check("R7", "first word held", vld_a, 1);
    check("R7", "in_ready low while stalled", rdy_a, 0);
    in_data = 23'h0ABCDE;
    repeat (2) @(negedge clk);
    check("R8", "out_valid held", vld_a, 1);
    check("R8", "out_res held", res_a, 3);
    out_ready = 1'b1;
    #1 check("R7", "in_ready with drain", rdy_a, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "second word after stall", res_a, 12);
    check("R7", "second word valid", vld_a, 1);
    @(negedge clk);
    check("R7", "empty after drain", vld_a, 0);

    report();
  end

endmodule